// File: doc/BRIEF.md
# Stopping-Time Range Sweep Controller

This controller walks an external step unit through every odd starting value from 3 up to a programmable upper bound. For each value it feeds the trajectory back through the step unit until the result drops strictly below that value's own start, and it counts the steps taken. The step arithmetic is not part of this block. The step unit receives a value, returns the next value of the map, and raises a flag when the result does not fit the fixed datapath width.

Over a sweep the controller gathers these statistics:
- how many values it processed;
- the total number of steps issued;
- the longest stopping time and the start that produced it;
- a count of trajectories abandoned on overflow;
- a count of trajectories abandoned on a programmable step limit.

A map with growing trajectories, such as 5n+1, therefore ends in a counter rather than in a wrapped value or an endless loop. A one-cycle `go` pulse clears all statistics and starts a sweep. `done` stays high until the next accepted `go`.

Top module: `sweep_ctrl`

## Requirements
- R1: After reset, `done` and `step_req` are 0, and every statistic output is 0.
- R2: A `go` pulse while idle or done clears all statistics and processes each odd value s with 3 <= s <= `range_end` exactly once, in ascending order. `checked_cnt` ends equal to the number of such values, including when `range_end` is the largest W-bit value. When `range_end` < 3, `done` rises with `checked_cnt` = 0.
- R3: `step_req` stays high and `step_in` stays stable until `step_ack`. The result is taken from `step_out`/`step_ovf` in the cycle where `step_req` and `step_ack` are both high. The first request for a value carries the start value itself.
- R4: A value is finished when a step result without overflow is strictly less than its own start. Its stopping time is the number of steps taken.
- R5: `max_stop` and `max_arg` hold the largest stopping time among finished values and its start. On a tie, the smaller start is kept. `max_arg` is odd whenever `max_stop` is nonzero.
- R6: `total_steps` counts every step issued during the sweep, including the steps of abandoned trajectories.
- R7: A step result with `step_ovf` = 1 abandons the value and increments `ovf_cnt`. This overflow test takes priority over the other two tests.
- R8: A value not finished after `step_limit` steps (at least one step) is abandoned and increments `div_cnt`.
- R9: `done` holds, and the statistics stay constant, until the next `go`. A `go` during a running sweep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, clears statistics |
| range_end | input | W | Largest start value, inclusive |
| step_limit | input | SW | Maximum steps per trajectory |
| step_req | output | 1 | Step request to the step unit |
| step_in | output | W | Current trajectory value |
| step_ack | input | 1 | Step result valid |
| step_out | input | W | Next trajectory value |
| step_ovf | input | 1 | Result exceeded W bits |
| done | output | 1 | Sweep finished |
| checked_cnt | output | CW | Values processed |
| total_steps | output | TW | Steps issued |
| max_stop | output | SW | Longest stopping time |
| max_arg | output | W | Start value of the longest stopping time |
| div_cnt | output | CW | Trajectories stopped by the step limit |
| ovf_cnt | output | CW | Trajectories stopped by overflow |

## Verification
A wrong start value or a skipped advance shows up at once on `step_in`: the first request for each value must carry that value. A corrupted step count or a wrong termination order does not show until `done` rises. It then appears as a mismatch in `total_steps`, `max_stop`, `max_arg` or the two abandon counters against a reference sweep. The bench's step unit answers after a random delay and checks that the request holds steady while it waits. The bench checks a known tie over the range up to 15. It also checks a sweep to the largest 12-bit bound, where the start counter would wrap.

// File: rtl/sweep_ctrl.sv
module sweep_ctrl #(
  parameter int W  = 32,
  parameter int SW = 16,
  parameter int CW = 32,
  parameter int TW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [W-1:0]  range_end,
  input  logic [SW-1:0] step_limit,
  output logic          step_req,
  output logic [W-1:0]  step_in,
  input  logic          step_ack,
  input  logic [W-1:0]  step_out,
  input  logic          step_ovf,
  output logic          done,
  output logic [CW-1:0] checked_cnt,
  output logic [TW-1:0] total_steps,
  output logic [SW-1:0] max_stop,
  output logic [W-1:0]  max_arg,
  output logic [CW-1:0] div_cnt,
  output logic [CW-1:0] ovf_cnt
);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_STEP, S_CHECK, S_NEXT, S_DONE} st_t;

  localparam logic [W-1:0] FIRST = W'(3);

  st_t           st;
  logic [W-1:0]  start, traj;
  logic [SW-1:0] steps;
  logic          ovf_seen;

  wire accept  = go && (st == S_IDLE || st == S_DONE);
  wire last_one = ({1'b0, start} + (W+1)'(2)) > {1'b0, range_end};

  assign step_req = (st == S_STEP);
  assign step_in  = traj;
  assign done     = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      start       <= '0;
      traj        <= '0;
      steps       <= '0;
      ovf_seen    <= 1'b0;
      checked_cnt <= '0;
      total_steps <= '0;
      max_stop    <= '0;
      max_arg     <= '0;
      div_cnt     <= '0;
      ovf_cnt     <= '0;
    end else if (accept) begin
      st          <= S_LOAD;
      start       <= FIRST;
      checked_cnt <= '0;
      total_steps <= '0;
      max_stop    <= '0;
      max_arg     <= '0;
      div_cnt     <= '0;
      ovf_cnt     <= '0;
    end else begin
      case (st)
        S_LOAD: begin
          if (start > range_end) st <= S_DONE;
          else begin
            traj  <= start;
            steps <= '0;
            st    <= S_STEP;
          end
        end
        S_STEP: begin
          if (step_ack) begin
            traj        <= step_out;
            ovf_seen    <= step_ovf;
            steps       <= steps + 1'b1;
            total_steps <= total_steps + 1'b1;
            st          <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (ovf_seen) begin
            ovf_cnt <= ovf_cnt + 1'b1;
            st      <= S_NEXT;
          end else if (traj < start) begin
            if (steps > max_stop) begin
              max_stop <= steps;
              max_arg  <= start;
            end
            st <= S_NEXT;
          end else if (steps >= step_limit) begin
            div_cnt <= div_cnt + 1'b1;
            st      <= S_NEXT;
          end else begin
            st <= S_STEP;
          end
        end
        S_NEXT: begin
          checked_cnt <= checked_cnt + 1'b1;
          start       <= start + W'(2);
          st          <= last_one ? S_DONE : S_LOAD;
        end
        default: ;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    step_req && !step_ack && !go |=> step_req && $stable(step_in)); // R3

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |-> (steps == '0 || steps < step_limit)); // R8

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !go |=> done && $stable(checked_cnt) && $stable(total_steps)); // R9

  AST_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, ovf_cnt} + {1'b0, div_cnt}) <= {1'b0, checked_cnt}); // R7

  AST_CHECKED_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> checked_cnt >= $past(checked_cnt)); // R2

  AST_MAX_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    max_stop != '0 |-> max_arg[0]); // R5

endmodule

// File: tb/sweep_ctrl_bench.sv
module sweep_ctrl_bench;
  localparam int W = 12, SW = 16, CW = 32, TW = 48;

  logic clk = 0, rst_n = 0, go = 0;
  logic [W-1:0] range_end = '0;
  logic [SW-1:0] step_limit = '0;
  logic step_req, step_ack = 0, step_ovf = 0, done;
  logic [W-1:0] step_in, step_out = '0;
  logic [CW-1:0] checked_cnt, div_cnt, ovf_cnt;
  logic [TW-1:0] total_steps;
  logic [SW-1:0] max_stop;
  logic [W-1:0] max_arg;

  sweep_ctrl #(.W(W), .SW(SW), .CW(CW), .TW(TW)) u_sweep_ctrl (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int mapx = 3;
  int pending = 0, lat = 0, r3_bad = 0, reqs = 0;
  logic [W-1:0] held;
  longint e_chk, e_tot, e_max, e_arg, e_div, e_ovf;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void do_step(input longint n, output longint r, output bit o);
    longint v = mapx * n + 1;
    while (v[0] == 1'b0) v = v >>> 1;
    o = v >= (64'd1 << W);
    r = v & ((64'd1 << W) - 1);
  endfunction

  function automatic void ref_sweep(input longint lim_end, input longint lim);
    longint t, k, r; bit o;
    e_chk = 0; e_tot = 0; e_max = 0; e_arg = 0; e_div = 0; e_ovf = 0;
    for (longint s = 3; s <= lim_end; s += 2) begin
      t = s; k = 0;
      forever begin
        do_step(t, r, o); t = r; k++; e_tot++;
        if (o) begin e_ovf++; break; end
        if (t < s) begin
          if (k > e_max) begin e_max = k; e_arg = s; end
          break;
        end
        if (k >= lim) begin e_div++; break; end
      end
      e_chk++;
    end
  endfunction

  // step unit model with random latency
  always @(negedge clk) begin
    longint r; bit o;
    if (step_ack) step_ack = 0;
    else if (step_req) begin
      if (pending == 0) begin
        pending = 1; held = step_in; lat = $urandom % 3; reqs++;
      end else if (step_in !== held) r3_bad++;
      if (lat == 0) begin
        do_step(step_in, r, o);
        step_out = r[W-1:0]; step_ovf = o; step_ack = 1; pending = 0;
      end else lat--;
    end
  end

  always @(posedge clk) cyc++;

  always @(negedge clk) if (cyc >= 190000) begin
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic pulse_go();
    @(negedge clk); go = 1;
    @(negedge clk); go = 0;
  endtask

  task automatic run(input longint e, input longint lim, input int x, input bit kick);
    mapx = x; range_end = W'(e); step_limit = SW'(lim);
    ref_sweep(e, lim);
    pulse_go();
    if (kick) begin
      repeat (40) @(negedge clk);
      go = 1; @(negedge clk); go = 0; // R9: ignored while running
    end
    while (!done) @(negedge clk);
    check("R2", "checked_cnt", checked_cnt, e_chk);
    check("R6", "total_steps", total_steps, e_tot);
    check("R4", "max_stop", max_stop, e_max);
    check("R5", "max_arg", max_arg, e_arg);
    check("R8", "div_cnt", div_cnt, e_div);
    check("R7", "ovf_cnt", ovf_cnt, e_ovf);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", "done", done, 0);
    check("R1", "step_req", step_req, 0);
    check("R1", "checked_cnt", checked_cnt, 0);
    check("R1", "total_steps", total_steps, 0);
    check("R1", "max_stop", max_stop, 0);
    rst_n = 1;
    @(negedge clk);

    run(2, 10, 3, 0);                       // R2 empty range
    check("R2", "done on empty range", done, 1);
    run(3, 10, 3, 0);                       // single value
    run(15, 20, 3, 0);                      // R5 tie 7 vs 15
    check("R5", "tie keeps 7", max_arg, 7);
    check("R4", "longest is 4", max_stop, 4);
    run(41, 6, 5, 0);                       // R8 R7 with 5n+1
    repeat (20) @(negedge clk);
    check("R9", "done held", done, 1);
    check("R9", "checked stable", checked_cnt, e_chk);
    run(301, 30, 3, 1);                     // R9 go ignored mid-sweep
    run(4095, 50, 3, 0);                    // R2 top of range
    for (int i = 0; i < 6; i++)
      run($urandom % 300, 1 + $urandom % 40, ($urandom % 2) ? 5 : 3, 0);

    check("R3", "requests seen", reqs > 0, 1);
    check("R3", "request stable while waiting", r3_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule